// File: doc/BRIEF.md
# Bus access self-test target

This block is a small memory-mapped target that occupies a 4 KB window on a simple synchronous register bus. Host software uses it to confirm that it can issue byte, halfword and word writes to the right lane with the right data. Software picks a test by writing its number into a select register. The block then shows the access width, the window offset and the value that the test expects. It counts every write that arrives at that offset with exactly that width and data, and it offers a short zero-terminated ASCII name for the test.

The test table is a constant inside the block. Test 0 is a byte test, test 1 is a halfword test and test 2 is a word test. Every higher number reports width 0, which means "unsupported". Software can therefore step upward through the test numbers until it reads an unsupported width, and stop there.

The bus carries a byte address, a 4-bit byte enable, 32-bit write data and registered 32-bit read data. Byte enable bit i covers `bus_wdata[8i+7:8i]`, which is byte address (`bus_addr` with its low two bits cleared) + i. The low two address bits are ignored. Multi-byte fields are little-endian: the lowest address is in bits 7:0.

Top module: `acc_probe_target`

## Requirements
- R1: After reset, test 0 is selected, the hit counter is 0 and `bus_rdata` is 0.
- R2: A write to word 0x00 with `bus_be[0]` set loads `bus_wdata[7:0]` as the test number. A read of word 0x00 returns 0 in bits 7:0 and 31:16, and the selected width in bits 15:8. A write to word 0x00 with `bus_be[0]` clear does not change the selection.
- R3: For test numbers 3 to 255, the width, offset, data and name words all read 0. No write is counted while such a test is selected.
- R4: Word 0x04 returns the test's window offset and word 0x08 returns its data value, both as 32-bit little-endian fields.
- R5: Word 0x0C returns the hit counter. Every select write clears it to 0.
- R6: The counter rises by exactly one for each bus write in which all three of these hold: the address word equals the offset's word, the byte enables equal the width mask (0001, 0011 or 1111) shifted left by offset[1:0], and the enabled write bytes equal the data value shifted to that lane.
- R7: A write that differs from the test in address word, byte enables or any enabled data byte leaves the counter unchanged.
- R8: Words 0x10 to 0x1F hold the test name as ASCII, first character in bits 7:0 of word 0x10. The name is zero-terminated: word 0x10 holds the four characters and words 0x14 to 0x1C read 0.
- R9: Read data appears on `bus_rdata` on the clock edge after the read request and holds until the next read. Reads from 0x20 up to the end of the window return 0.
- R10: Writes to words 0x04, 0x08, 0x0C and 0x10 to 0x1F do not change what those words read back.
- R11: The test table is:

| Test | Width | Offset | Data | Name |
|---|---|---|---|---|
| 0 | 1 | 0x101 | 0x5A | "byte" |
| 1 | 2 | 0x202 | 0xBEEF | "half" |
| 2 | 4 | 0x304 | 0x1234ABCD | "word" |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W (12) | Byte address within the window |
| bus_be | input | 4 | Byte enables for a write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
Each result arrives one clock edge after the bus cycle that caused it. A select write changes the header from the next edge onward. A matching write raises the counter at its own edge. Read data registered at the request edge can be sampled at the following falling edge.

The bench drives each request on a falling edge and drops `bus_sel` one time unit after the rising edge that accepts it. Explicit checks issue a read and sample `bus_rdata` on the falling edge right after that read's rising edge. A behavioural model advances at every rising edge, and its read word is compared with `bus_rdata` on every falling edge.

// File: rtl/acc_probe_target.sv
module acc_probe_target #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);

  localparam int WA = ADDR_W - 2;
  localparam logic [7:0] LAST_TEST = 8'd2;

  logic [7:0]  sel_q;
  logic [31:0] hits_q;
  logic [7:0]  t_width;
  logic [31:0] t_off, t_data, t_name;
  logic [WA-1:0] widx;

  assign widx = bus_addr[ADDR_W-1:2];

  always_comb begin
    t_width = '0;
    t_off   = '0;
    t_data  = '0;
    t_name  = '0;
    case (sel_q)
      8'd0: begin t_width = 8'd1; t_off = 32'h101; t_data = 32'h5A;       t_name = 32'h65747962; end
      8'd1: begin t_width = 8'd2; t_off = 32'h202; t_data = 32'hBEEF;     t_name = 32'h666c6168; end
      8'd2: begin t_width = 8'd4; t_off = 32'h304; t_data = 32'h1234ABCD; t_name = 32'h64726f77; end
      default: ;
    endcase
  end

  logic [3:0]  base_be, exp_be;
  logic [31:0] lane_data, be_bits;
  logic        sel_wr, hit, rd_req;

  assign base_be   = (t_width == 8'd1) ? 4'b0001 :
                     (t_width == 8'd2) ? 4'b0011 :
                     (t_width == 8'd4) ? 4'b1111 : 4'b0000;
  assign exp_be    = base_be << t_off[1:0];
  assign lane_data = t_data << {t_off[1:0], 3'b000};
  assign be_bits   = {{8{bus_be[3]}}, {8{bus_be[2]}}, {8{bus_be[1]}}, {8{bus_be[0]}}};

  assign rd_req = bus_sel && !bus_we;
  assign sel_wr = bus_sel && bus_we && (widx == '0) && bus_be[0];
  assign hit    = bus_sel && bus_we && (exp_be != 4'b0000)
               && (widx == t_off[ADDR_W-1:2])
               && (bus_be == exp_be)
               && ((bus_wdata & be_bits) == lane_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= '0;
      hits_q <= '0;
    end else if (sel_wr) begin
      sel_q  <= bus_wdata[7:0];
      hits_q <= '0;
    end else if (hit) begin
      hits_q <= hits_q + 32'd1;
    end
  end

  logic [31:0] rd_word;
  always_comb begin
    case (widx)
      WA'(0):  rd_word = {16'h0, t_width, 8'h0};
      WA'(1):  rd_word = t_off;
      WA'(2):  rd_word = t_data;
      WA'(3):  rd_word = hits_q;
      WA'(4):  rd_word = t_name;
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (rd_req) bus_rdata <= rd_word;
  end

  a_r5_clear_on_select: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> hits_q == 32'd0);

  a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> hits_q == $past(hits_q) + 32'd1);

  a_r7_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !sel_wr) |=> $stable(hits_q));

  a_r3_unsupported: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q > LAST_TEST) |-> (t_width == 8'd0 && exp_be == 4'b0000));

  a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> $stable(bus_rdata));

  a_r9_beyond_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && widx >= WA'(8)) |=> bus_rdata == 32'd0);

endmodule

// File: tb/tb_acc_probe_target.sv
module tb_acc_probe_target;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int compared = 0, mismatched = 0;
  bit done = 0;

  always #4 clk = ~clk;

  acc_probe_target dut (.clk, .rst_n, .bus_sel, .bus_we, .bus_addr,
                        .bus_be, .bus_wdata, .bus_rdata);

  function automatic int r_width(int t);
    case (t) 0: return 1; 1: return 2; 2: return 4; default: return 0; endcase
  endfunction
  function automatic int r_off(int t);
    case (t) 0: return 'h101; 1: return 'h202; 2: return 'h304; default: return 0; endcase
  endfunction
  function automatic logic [31:0] r_data(int t);
    case (t) 0: return 32'h5A; 1: return 32'hBEEF; 2: return 32'h1234ABCD; default: return 0; endcase
  endfunction
  function automatic logic [31:0] pack4(string s);
    return {s[3], s[2], s[1], s[0]};
  endfunction
  function automatic logic [31:0] r_name(int t);
    case (t) 0: return pack4("byte"); 1: return pack4("half"); 2: return pack4("word"); default: return 0; endcase
  endfunction

  int m_sel, m_hits;
  logic [31:0] m_rdata;

  function automatic logic [31:0] m_word(int a);
    int w = a / 4;
    case (w)
      0: return r_width(m_sel) * 256;
      1: return r_off(m_sel);
      2: return r_data(m_sel);
      3: return m_hits;
      4: return r_name(m_sel);
      default: return 0;
    endcase
  endfunction

  function automatic bit m_match(int a, logic [3:0] be, logic [31:0] d);
    int base = (a / 4) * 4;
    int w = r_width(m_sel);
    int o = r_off(m_sel);
    logic [31:0] v = r_data(m_sel);
    if (w == 0) return 0;
    for (int i = 0; i < 4; i++) begin
      bit want = (base + i >= o) && (base + i < o + w);
      if (be[i] != want) return 0;
      if (want && d[8*i +: 8] != v[8*(base + i - o) +: 8]) return 0;
    end
    return 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sel = 0; m_hits = 0; m_rdata = 0;
    end else if (bus_sel) begin
      if (!bus_we) m_rdata = m_word(int'(bus_addr));
      else if (bus_addr < 12'h4 && bus_be[0]) begin
        m_sel = int'(bus_wdata[7:0]); m_hits = 0;
      end else if (m_match(int'(bus_addr), bus_be, bus_wdata)) m_hits++;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      compared++;
      if (bus_rdata !== m_rdata) begin
        mismatched++;
        $display("FAIL R9 model compare: actual %h expected %h", bus_rdata, m_rdata);
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = 12'(a); bus_be = be; bus_wdata = d;
    @(posedge clk); #1 bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(int a, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = 12'(a); bus_be = 0;
    @(posedge clk); #1 bus_sel = 0;
    @(negedge clk);
    chk(tag, bus_rdata, exp);
  endtask

  initial begin
    #(8 * 200000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 rdata after reset", bus_rdata, 32'h0);
    rd('h0C, 32'h0, "R1 counter after reset");
    rd('h00, 32'h100, "R1 test0 selected");
    rd('h04, 32'h101, "R4 R11 test0 offset");
    rd('h08, 32'h5A, "R4 R11 test0 data");
    rd('h10, 32'h65747962, "R8 R11 test0 name");
    wr('h100, 4'b0010, 32'h00005A00);
    wr('h100, 4'b0010, 32'hFFFF5AFF);
    rd('h0C, 32'd2, "R6 byte hits");
    wr('h100, 4'b0011, 32'h00005A5A);
    wr('h100, 4'b0010, 32'h00005B00);
    wr('h104, 4'b0010, 32'h00005A00);
    wr('h100, 4'b0001, 32'h0000005A);
    rd('h0C, 32'd2, "R7 byte misses ignored");
    wr('h04, 4'b1111, 32'hFFFFFFFF);
    wr('h0C, 4'b1111, 32'h55);
    wr('h10, 4'b1111, 32'h0);
    wr('h00, 4'b1110, 32'hFFFFFF03);
    rd('h04, 32'h101, "R10 offset unchanged");
    rd('h0C, 32'd2, "R10 counter unchanged");
    rd('h10, 32'h65747962, "R10 name unchanged");
    rd('h00, 32'h100, "R2 select needs be0");
    wr('h00, 4'b0001, 32'h1);
    rd('h00, 32'h200, "R2 R11 test1 width");
    rd('h0C, 32'd0, "R5 cleared on select");
    rd('h04, 32'h202, "R11 test1 offset");
    rd('h08, 32'hBEEF, "R11 test1 data");
    rd('h10, 32'h666c6168, "R8 test1 name");
    wr('h200, 4'b1100, 32'hBEEF0000);
    wr('h200, 4'b0011, 32'h0000BEEF);
    wr('h200, 4'b1110, 32'hBEEF0000);
    rd('h0C, 32'd1, "R6 R7 halfword hits");
    wr('h00, 4'b1111, 32'hAABBCC02);
    rd('h00, 32'h400, "R2 test2 width");
    repeat (3) wr('h304, 4'b1111, 32'h1234ABCD);
    wr('h304, 4'b1111, 32'h1234ABCC);
    wr('h300, 4'b1111, 32'h1234ABCD);
    rd('h0C, 32'd3, "R6 R7 word hits");
    rd('h10, 32'h64726f77, "R8 test2 name");
    rd('h14, 32'h0, "R8 terminator");
    rd('h1C, 32'h0, "R8 name tail");
    wr('h00, 4'b0001, 32'h3);
    rd('h00, 32'h0, "R3 test3 unsupported");
    rd('h04, 32'h0, "R3 test3 offset");
    rd('h08, 32'h0, "R3 test3 data");
    rd('h10, 32'h0, "R3 test3 name");
    wr('h304, 4'b1111, 32'h1234ABCD);
    wr('h101, 4'b0000, 32'h0);
    rd('h0C, 32'd0, "R3 no count when unsupported");
    wr('h00, 4'b0001, 32'hFF);
    rd('h00, 32'h0, "R3 test255 unsupported");
    rd('h20, 32'h0, "R9 beyond header");
    rd('hFFC, 32'h0, "R9 window end");
    repeat (4) @(negedge clk);
    chk("R9 rdata held", bus_rdata, 32'h0);
    rd('h08, 32'h0, "R9 read after idle");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule